// File: doc/BRIEF.md
# Boot node election controller

Each node on a shared bus carries one copy of this controller. After reset it takes the node's 8-bit identifier and uses it as the arbitration priority. It waits for the local self-test to finish. It then joins a bus-wide election, which leaves exactly one node as the boot node. Every other node becomes an application node that waits for its startup messages.

In the default mode the node watches a shared toggle line. It requests the bus for one null cycle only after that line has stayed still for a set number of cycles. The bus is granted to the highest priority. A node that sees its own identifier on the grant becomes the boot node: it raises a boot flag and gives a one-cycle fetch pulse that carries the reset vector. Any other grant value makes the node an application node.

In the broadcast mode the node skips the quiet wait. The first message it sees on the bus decides its role: its own identifier coming back makes it the boot node. Interrupt delivery to the node is masked from the start of the election until the node is running.

Top module: `boot_elect`

## Requirements
- R1: While reset is asserted, boot_o, fetch_o, wait_o, started_o, arb_req_o and intr_mask_o are all 0. The node identifier is captured during reset, and later changes on node_id_i have no effect. arb_prio_o carries the captured identifier.
- R2: arb_req_o stays 0 and intr_mask_o stays 0 until a cycle with bist_done_i = 1 has been sampled.
- R3: In mode 0 (bcast_mode_i = 0), arb_req_o rises QUIET_CYCLES + 1 clock edges after the last change of tgl_i (default 16, so 17 edges). A change of tgl_i during the wait restarts the count.
- R4: While arb_req_o is 1, a cycle with bus_valid_i = 1 decides the node's role at the next edge. If bus_id_i equals the captured identifier, boot_o is set. Otherwise wait_o is set and boot_o stays 0.
- R5: fetch_o is a single-cycle pulse in the cycle in which boot_o first becomes 1. fetch_addr_o is 0xFFFF_FFF0.
- R6: bus_valid_i is ignored while arb_req_o is 0, even if bus_id_i equals the node's own identifier.
- R7: In mode 1 (bcast_mode_i = 1), arb_req_o is 1 in the cycle after bist_done_i is sampled, whatever tgl_i does. The first bus message seen then decides the role, using the same rule as R4.
- R8: A waiting node moves to started_o = 1 and wait_o = 0 only when two messages addressed to its identifier arrive in this order: first msg_kind_i = 0 (init), then msg_kind_i = 1 (startup). A startup with no earlier own init has no effect, and neither has any message to another identifier. started_o stays 1 until reset.
- R9: intr_mask_o rises together with the start of the election. It stays 1 until the node becomes the boot node or started_o rises, and then falls to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| node_id_i | input | 8 | Node identifier, captured during reset |
| bist_done_i | input | 1 | Self-test complete strobe |
| bcast_mode_i | input | 1 | 0: quiet-line election, 1: broadcast election |
| tgl_i | input | 1 | Sampled shared toggle line |
| arb_req_o | output | 1 | Bus request for the null cycle or the broadcast |
| arb_prio_o | output | 8 | Priority offered with the request |
| bus_valid_i | input | 1 | Grant or broadcast message present on the bus |
| bus_id_i | input | 8 | Identifier of the granted or broadcasting node |
| msg_valid_i | input | 1 | Startup-sequence message present |
| msg_kind_i | input | 1 | 0: init, 1: startup |
| msg_id_i | input | 8 | Target identifier of the message |
| boot_o | output | 1 | Node is the boot node |
| fetch_o | output | 1 | One-cycle fetch start pulse |
| fetch_addr_o | output | 32 | Reset vector address for the fetch |
| wait_o | output | 1 | Node waits for its startup messages |
| started_o | output | 1 | Application node has been started |
| intr_mask_o | output | 1 | Interrupt delivery masked |

## Verification
The assertions check these properties on every cycle:
- boot and wait are never set together;
- the fetch pulse lasts one cycle and comes only with the boot flag;
- the boot flag follows a cycle in which the node was requesting;
- started_o never falls;
- the mask is up whenever the node is requesting or waiting;
- in mode 0 a request never starts straight after a toggle.

Only the bench scenarios can show the remaining behaviours. These are the exact quiet-window length and its restart, and the effect of the identifier captured during reset on who wins. They also include the ignored grants and messages, the required order of init before startup, and the broadcast-mode outcomes.

// File: rtl/boot_elect.sv
module boot_elect #(
  parameter int          QUIET_CYCLES = 16,
  parameter int          ID_W         = 8,
  parameter logic [31:0] RESET_VEC    = 32'hFFFF_FFF0
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [ID_W-1:0] node_id_i,
  input  logic            bist_done_i,
  input  logic            bcast_mode_i,
  input  logic            tgl_i,
  output logic            arb_req_o,
  output logic [ID_W-1:0] arb_prio_o,
  input  logic            bus_valid_i,
  input  logic [ID_W-1:0] bus_id_i,
  input  logic            msg_valid_i,
  input  logic            msg_kind_i,
  input  logic [ID_W-1:0] msg_id_i,
  output logic            boot_o,
  output logic            fetch_o,
  output logic [31:0]     fetch_addr_o,
  output logic            wait_o,
  output logic            started_o,
  output logic            intr_mask_o
);
  localparam int CNT_W = $clog2(QUIET_CYCLES + 1);

  typedef enum logic [2:0] {S_IDLE, S_QUIET, S_REQ, S_BOOT, S_WAIT, S_RUN} st_t;

  st_t             st;
  logic [ID_W-1:0] id_q;
  logic [CNT_W-1:0] cnt;
  logic            tgl_q, armed, fetch_q, mask_q;
  logic            tgl_edge, own_msg;

  assign tgl_edge = tgl_i ^ tgl_q;
  assign own_msg  = msg_valid_i && (msg_id_i == id_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      id_q    <= node_id_i;
      cnt     <= '0;
      tgl_q   <= 1'b0;
      armed   <= 1'b0;
      fetch_q <= 1'b0;
      mask_q  <= 1'b0;
    end else begin
      tgl_q   <= tgl_i;
      fetch_q <= 1'b0;
      case (st)
        S_IDLE: if (bist_done_i) begin
          st     <= bcast_mode_i ? S_REQ : S_QUIET;
          cnt    <= '0;
          mask_q <= 1'b1;
        end
        S_QUIET: begin
          if (tgl_edge) cnt <= '0;
          else if (cnt == CNT_W'(QUIET_CYCLES - 1)) st <= S_REQ;
          else cnt <= cnt + 1'b1;
        end
        S_REQ: if (bus_valid_i) begin
          if (bus_id_i == id_q) begin
            st      <= S_BOOT;
            fetch_q <= 1'b1;
            mask_q  <= 1'b0;
          end else begin
            st <= S_WAIT;
          end
        end
        S_WAIT: if (own_msg) begin
          if (!msg_kind_i) armed <= 1'b1;
          else if (armed) begin
            st     <= S_RUN;
            mask_q <= 1'b0;
          end
        end
        default: ;
      endcase
    end
  end

  assign arb_req_o    = (st == S_REQ);
  assign arb_prio_o   = id_q;
  assign boot_o       = (st == S_BOOT);
  assign fetch_o      = fetch_q;
  assign fetch_addr_o = RESET_VEC;
  assign wait_o       = (st == S_WAIT);
  assign started_o    = (st == S_RUN);
  assign intr_mask_o  = mask_q;

  a_r4_role_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(boot_o && wait_o));
  a_r5_fetch_single: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_o |=> !fetch_o);
  a_r5_fetch_with_boot: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_o |-> boot_o);
  a_r6_boot_after_req: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(boot_o) |-> $past(arb_req_o));
  a_r8_started_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    started_o |=> started_o);
  a_r9_mask_held: assert property (@(posedge clk) disable iff (!rst_n)
    (arb_req_o || wait_o) |-> intr_mask_o);
  a_r3_req_after_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(arb_req_o) && !bcast_mode_i) |-> ($past(tgl_i) == $past(tgl_i, 2)));
endmodule

// File: tb/boot_elect_tb_top.sv
module boot_elect_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  node_id = 8'h00;
  logic        bist = 1'b0, mode = 1'b0, tgl = 1'b0;
  logic        inj_v = 1'b0, comp_en = 1'b0;
  logic [7:0]  inj_id = 8'h00, comp_id = 8'h00;
  logic        msg_v = 1'b0, msg_k = 1'b0;
  logic [7:0]  msg_id = 8'h00;
  logic        req, boot, fetch, waitn, started, mask;
  logic [7:0]  prio;
  logic [31:0] faddr;
  logic        bus_v;
  logic [7:0]  bus_id;
  logic        comp_req;

  int errs = 0, checks = 0;
  int exp_q[$];
  bit done = 0;

  localparam int EV_BOOT = 1, EV_WAIT = 2, EV_START = 3;

  always #4 clk = ~clk;

  assign comp_req = comp_en && req;
  assign bus_v    = inj_v || req || comp_req;
  assign bus_id   = inj_v ? inj_id : ((comp_req && comp_id > prio) ? comp_id : prio);

  boot_elect dut_i (
    .clk(clk), .rst_n(rst_n), .node_id_i(node_id), .bist_done_i(bist),
    .bcast_mode_i(mode), .tgl_i(tgl), .arb_req_o(req), .arb_prio_o(prio),
    .bus_valid_i(bus_v), .bus_id_i(bus_id), .msg_valid_i(msg_v),
    .msg_kind_i(msg_k), .msg_id_i(msg_id), .boot_o(boot), .fetch_o(fetch),
    .fetch_addr_o(faddr), .wait_o(waitn), .started_o(started), .intr_mask_o(mask)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  logic pb, pw, ps;
  always @(negedge clk) begin
    if (!rst_n) begin
      pb = 0; pw = 0; ps = 0;
    end else begin
      if (boot && !pb) begin
        if (exp_q.size() == 0) chk("R4 unexpected boot", 1, 0);
        else chk("R4 boot event", EV_BOOT, exp_q.pop_front());
        chk("R5 fetch pulse", fetch, 1);
        chk("R5 fetch address", faddr, 32'hFFFF_FFF0);
      end
      if (waitn && !pw) begin
        if (exp_q.size() == 0) chk("R4 unexpected wait", 1, 0);
        else chk("R4 wait event", EV_WAIT, exp_q.pop_front());
      end
      if (started && !ps) begin
        if (exp_q.size() == 0) chk("R8 unexpected start", 1, 0);
        else chk("R8 start event", EV_START, exp_q.pop_front());
      end
      pb = boot; pw = waitn; ps = started;
    end
  end

  task automatic start(logic [7:0] id, logic m);
    @(negedge clk);
    rst_n = 0; node_id = id; mode = m; tgl = 0; bist = 0;
    inj_v = 0; comp_en = 0; msg_v = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
  endtask

  task automatic pulse_bist();
    bist = 1;
    @(negedge clk);
    bist = 0;
  endtask

  task automatic send(logic k, logic [7:0] id);
    msg_v = 1; msg_k = k; msg_id = id;
    @(negedge clk);
    msg_v = 0;
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      errs++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    // Scenario A: reset state, ID capture, quiet-line win
    @(negedge clk);
    node_id = 8'h40;
    chk("R1 boot in reset", boot, 0);
    chk("R1 wait in reset", waitn, 0);
    chk("R1 started in reset", started, 0);
    chk("R1 req in reset", req, 0);
    chk("R1 fetch in reset", fetch, 0);
    chk("R1 mask in reset", mask, 0);
    start(8'h40, 0);
    node_id = 8'h01;
    comp_en = 1; comp_id = 8'h20;
    repeat (5) @(negedge clk);
    chk("R2 no req before self-test", req, 0);
    chk("R2 no mask before self-test", mask, 0);
    pulse_bist();
    chk("R9 mask at election start", mask, 1);
    for (int i = 0; i < 5; i++) begin
      tgl = ~tgl;
      @(negedge clk);
      chk("R3 no req while toggling", req, 0);
    end
    repeat (15) @(negedge clk);
    chk("R3 no req before quiet window ends", req, 0);
    exp_q.push_back(EV_BOOT);
    @(negedge clk);
    chk("R3 req after quiet window", req, 1);
    chk("R1 priority from captured id", prio, 8'h40);
    @(negedge clk);
    chk("R1 captured id wins", boot, 1);
    @(negedge clk);
    chk("R5 fetch single cycle", fetch, 0);
    chk("R9 mask cleared on win", mask, 0);
    chk("R4 boot held", boot, 1);

    // Scenario B: lose, restart of quiet count, startup ordering
    start(8'h10, 0);
    comp_en = 1; comp_id = 8'h30;
    pulse_bist();
    repeat (3) begin tgl = ~tgl; @(negedge clk); end
    repeat (10) @(negedge clk);
    tgl = ~tgl;
    @(negedge clk);
    repeat (15) @(negedge clk);
    chk("R3 count restarted by toggle", req, 0);
    exp_q.push_back(EV_WAIT);
    @(negedge clk);
    chk("R3 req after restarted window", req, 1);
    @(negedge clk);
    chk("R4 loser waits", waitn, 1);
    chk("R4 loser boot clear", boot, 0);
    chk("R9 mask held while waiting", mask, 1);
    send(1, 8'h10);
    chk("R8 startup without init ignored", started, 0);
    send(0, 8'h99);
    send(1, 8'h10);
    chk("R8 foreign init does not arm", started, 0);
    send(0, 8'h10);
    send(1, 8'h55);
    chk("R8 foreign startup ignored", waitn, 1);
    exp_q.push_back(EV_START);
    send(1, 8'h10);
    chk("R8 started after init then startup", started, 1);
    chk("R8 wait left", waitn, 0);
    chk("R9 mask cleared on start", mask, 0);
    send(0, 8'h10);
    send(1, 8'h10);
    repeat (3) @(negedge clk);
    chk("R8 started sticky", started, 1);

    // Scenario C: grant while not requesting is ignored
    start(8'h22, 0);
    pulse_bist();
    repeat (3) @(negedge clk);
    inj_v = 1; inj_id = 8'h22;
    @(negedge clk);
    inj_v = 0;
    chk("R6 no boot from idle grant", boot, 0);
    chk("R6 no wait from idle grant", waitn, 0);
    exp_q.push_back(EV_BOOT);
    for (int i = 0; i < 40 && !boot; i++) @(negedge clk);
    chk("R6 election proceeds normally", boot, 1);

    // Scenario D: broadcast mode, own message first
    start(8'h05, 1);
    tgl = ~tgl;
    exp_q.push_back(EV_BOOT);
    pulse_bist();
    chk("R7 req right after self-test", req, 1);
    @(negedge clk);
    chk("R7 own broadcast makes boot", boot, 1);

    // Scenario E: broadcast mode, another node first
    start(8'h05, 1);
    pulse_bist();
    chk("R7 req ignores toggle wait", req, 1);
    inj_v = 1; inj_id = 8'h07;
    exp_q.push_back(EV_WAIT);
    @(negedge clk);
    inj_v = 0;
    chk("R7 foreign broadcast makes wait", waitn, 1);
    chk("R7 boot clear", boot, 0);
    @(negedge clk);
    chk("R4 all expected events seen", exp_q.size(), 0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule